// File: doc/BRIEF.md
# Double-Precision Compare-to-Mask Unit

This unit evaluates a relational predicate between two 64-bit binary floating-point operands and turns the outcome into data that later logic can use directly as a mask. In scalar mode a single operand pair yields a full 64-bit word that is either every bit set (predicate true) or every bit clear (predicate false). In vector mode the unit takes a run of operand pairs, one per accepted transfer. It records the outcome for pair i in bit i of a mask word and delivers the mask when the run ends.

Operands arrive on a valid/ready stream. The predicate, the scalar/vector choice and the run length travel with each transfer, but in vector mode they are sampled only on the first pair of a run. Each result comes with an invalid-operation flag meant for a floating-point status register. Zeros of either sign, infinities and NaNs follow the usual floating-point ordering rules. Operands with a zero exponent field are read as zero.

Top module: `fcmp_mask_unit`

## Requirements
- R1: In scalar mode (`in_vec`=0), a pair accepted on a rising edge (in_valid and in_ready both high) produces a one-cycle `out_valid` pulse after that same edge. `out_data` is 64'hFFFF_FFFF_FFFF_FFFF when the predicate holds and 64'h0 when it does not.
- R2: `in_pred` selects the predicate with a fixed encoding: 2'b00 equal, 2'b01 not equal, 2'b10 a less than b, 2'b11 a less than or equal to b.
- R3: Positive and negative zero compare equal. Any operand whose exponent field (bits 62:52) is zero is treated as a zero of either sign, whatever its fraction.
- R4: An infinity (exponent all ones, fraction zero) equals an infinity of the same sign. Positive infinity is greater than every finite value, and negative infinity is less than every finite value.
- R5: If either operand is a NaN (exponent all ones, fraction nonzero), equal, less-than and less-or-equal are false and not-equal is true.
- R6: `out_invalid` is raised with a result when any operand of that operation is a signaling NaN (fraction bit 51 clear), for every predicate. A quiet NaN (fraction bit 51 set) raises it only for less-than and less-or-equal. In vector mode the flag is the OR over all pairs of the run.
- R7: In vector mode, the first pair of a run fixes the predicate and the run length. The mode, predicate and length inputs on the later pairs of the run are ignored. Bit i of the result mask is 1 exactly when the predicate holds for pair i. The result pulses `out_valid` after the edge that accepts the last pair, and idle cycles inside a run are allowed.
- R8: The run length L comes from `in_len`: a value of 1 to 64 is used as given, 0 is taken as 1, and values above 64 are taken as 64. Mask bits L and above are always 0.
- R9: During reset `out_valid` is low and `out_data` is zero. `in_ready` is high from the first edge after reset is released and stays high.
- R10: A new operation may be accepted on the edge right after the last pair of the previous one, and both results appear in order on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Unit can take an operand pair |
| in_a | input | 64 | First operand, binary64 |
| in_b | input | 64 | Second operand, binary64 |
| in_pred | input | 2 | Predicate select (R2) |
| in_vec | input | 1 | 1 = vector run, 0 = scalar |
| in_len | input | 7 | Vector run length (R8) |
| out_valid | output | 1 | Result pulse |
| out_data | output | 64 | All-ones/all-zeros word or element mask |
| out_invalid | output | 1 | Invalid-operation flag for this result |

## Verification
Two events can fall in the same cycle: closing a vector run, which registers the mask, and accepting the first pair of the next operation, which reloads the predicate, length and mask state. The bench starts a scalar compare on the edge right after a vector run's last pair, and starts a vector run on the edge right after a scalar compare. The scoreboard then requires both results in order with the right masks and flags. A stale bit or a lost result shows up as a mismatch in the second item.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int FP_W   = 64;
  localparam int EXP_LO = 52;
  localparam int QBIT   = 51;

  typedef enum logic [1:0] {
    PRED_EQ = 2'b00,
    PRED_NE = 2'b01,
    PRED_LT = 2'b10,
    PRED_LE = 2'b11
  } pred_e;

  typedef struct packed {
    logic            is_nan;
    logic            is_snan;
    logic [FP_W-1:0] key;
  } fp_view_t;

  // Map an operand onto an unsigned key whose integer order is the
  // floating-point order; all zero-exponent values share one key.
  function automatic fp_view_t fp_view(input logic [FP_W-1:0] x);
    fp_view_t v;
    logic [FP_W-EXP_LO-2:0] e;
    logic [EXP_LO-1:0]      f;
    e = x[FP_W-2:EXP_LO];
    f = x[EXP_LO-1:0];
    v.is_nan  = (&e) && (|f);
    v.is_snan = v.is_nan && !f[QBIT];
    if (e == '0)
      v.key = {1'b1, {(FP_W-1){1'b0}}};
    else if (x[FP_W-1])
      v.key = ~x;
    else
      v.key = {1'b1, x[FP_W-2:0]};
    return v;
  endfunction

  // Returns {hit, invalid}.
  function automatic logic [1:0] fp_pred_eval(input pred_e p,
                                              input fp_view_t a,
                                              input fp_view_t b);
    logic unord, sig, eq, lt, hit, inv;
    unord = a.is_nan | b.is_nan;
    sig   = a.is_snan | b.is_snan;
    eq    = !unord && (a.key == b.key);
    lt    = !unord && (a.key < b.key);
    case (p)
      PRED_EQ: begin hit = eq;       inv = sig;   end
      PRED_NE: begin hit = !eq;      inv = sig;   end
      PRED_LT: begin hit = lt;       inv = unord; end
      default: begin hit = lt | eq;  inv = unord; end
    endcase
    return {hit, inv};
  endfunction

endpackage

// File: rtl/fcmp_core.sv
module fcmp_core
  import fcmp_pkg::*;
(
  input  logic [FP_W-1:0] op_a,
  input  logic [FP_W-1:0] op_b,
  input  logic [1:0]      pred,
  output logic            hit,
  output logic            invalid,
  output logic            any_nan,
  output logic            any_snan
);

  fp_view_t   va, vb;
  logic [1:0] res;

  always_comb begin
    va       = fp_view(op_a);
    vb       = fp_view(op_b);
    res      = fp_pred_eval(pred_e'(pred), va, vb);
    hit      = res[1];
    invalid  = res[0];
    any_nan  = va.is_nan | vb.is_nan;
    any_snan = va.is_snan | vb.is_snan;
  end

endmodule

// File: rtl/fcmp_mask_acc.sv
module fcmp_mask_acc
  import fcmp_pkg::*;
#(
  parameter  int MAX_LEN = 64,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             vec_in,
  input  logic [1:0]       pred_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             hit,
  input  logic             inv,
  output logic [1:0]       pred_use,
  output logic             res_valid,
  output logic [FP_W-1:0]  res_data,
  output logic             res_inv,
  output logic             res_scalar,
  output logic [LEN_W-1:0] res_len
);

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
    if (l == '0)                  return LEN_W'(1);
    else if (l > LEN_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
    else                          return l;
  endfunction

  logic               active_q, inv_q;
  logic [LEN_W-1:0]   idx_q, len_q;
  logic [1:0]         pred_q;
  logic [MAX_LEN-1:0] mask_q;

  logic               cur_vec, last_elem, inv_acc;
  logic [LEN_W-1:0]   cur_len, elem_idx;
  logic [MAX_LEN-1:0] mask_next;

  always_comb begin
    pred_use  = active_q ? pred_q : pred_in;
    cur_vec   = active_q | vec_in;
    cur_len   = active_q ? len_q : eff_len(len_in);
    elem_idx  = active_q ? idx_q : '0;
    last_elem = (elem_idx == cur_len - LEN_W'(1));
    mask_next = (active_q ? mask_q : '0) | (MAX_LEN'(hit) << elem_idx);
    inv_acc   = inv | (active_q & inv_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      inv_q      <= 1'b0;
      idx_q      <= '0;
      len_q      <= '0;
      pred_q     <= '0;
      mask_q     <= '0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_inv    <= 1'b0;
      res_scalar <= 1'b0;
      res_len    <= '0;
    end else begin
      res_valid <= fire && (!cur_vec || last_elem);
      if (fire) begin
        res_inv    <= inv_acc;
        res_scalar <= !cur_vec;
        res_len    <= cur_len;
        res_data   <= cur_vec ? FP_W'(mask_next) : {FP_W{hit}};
        if (cur_vec) begin
          active_q <= !last_elem;
          idx_q    <= elem_idx + LEN_W'(1);
          mask_q   <= mask_next;
          inv_q    <= inv_acc;
          if (!active_q) begin
            len_q  <= cur_len;
            pred_q <= pred_in;
          end
        end
      end
    end
  end

  assert_scalar_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_scalar |-> (res_data == '0 || res_data == '1));

  assert_mask_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_scalar |-> ((res_data >> res_len) == '0));

  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q != '0 && idx_q < len_q));

  assert_result_follows_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(fire));

endmodule

// File: rtl/fcmp_mask_unit.sv
module fcmp_mask_unit
  import fcmp_pkg::*;
#(
  parameter  int MAX_LEN = 64,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_a,
  input  logic [FP_W-1:0]  in_b,
  input  logic [1:0]       in_pred,
  input  logic             in_vec,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  output logic [FP_W-1:0]  out_data,
  output logic             out_invalid
);

  logic             ready_q, fire;
  logic [1:0]       pred_use;
  logic             cmp_hit, cmp_inv, any_nan, any_snan;
  logic             res_scalar;
  logic [LEN_W-1:0] res_len;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign fire     = in_valid & ready_q;

  fcmp_core u_core (
    .op_a     (in_a),
    .op_b     (in_b),
    .pred     (pred_use),
    .hit      (cmp_hit),
    .invalid  (cmp_inv),
    .any_nan  (any_nan),
    .any_snan (any_snan)
  );

  fcmp_mask_acc #(.MAX_LEN(MAX_LEN)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .vec_in     (in_vec),
    .pred_in    (in_pred),
    .len_in     (in_len),
    .hit        (cmp_hit),
    .inv        (cmp_inv),
    .pred_use   (pred_use),
    .res_valid  (out_valid),
    .res_data   (out_data),
    .res_inv    (out_invalid),
    .res_scalar (res_scalar),
    .res_len    (res_len)
  );

  assert_nan_unordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && any_nan |-> (cmp_hit == (pred_use == PRED_NE)));

  assert_snan_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && any_snan |-> cmp_inv);

  assert_ready_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  assert_no_stray_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !any_nan |-> !cmp_inv);

endmodule

// File: tb/tb_fcmp_mask_unit.sv
module tb_fcmp_mask_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_pred = '0;
  logic        in_vec = 1'b0;
  logic [6:0]  in_len = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_invalid;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [63:0] q_data[$];
  logic        q_inv[$];
  string       q_tag[$];
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  fcmp_mask_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_pred(in_pred), .in_vec(in_vec),
    .in_len(in_len), .out_valid(out_valid), .out_data(out_data),
    .out_invalid(out_invalid)
  );

  function automatic logic [63:0] val(input int i);
    case (i)
      0:  return 64'h0000_0000_0000_0000; // +0
      1:  return 64'h8000_0000_0000_0000; // -0
      2:  return 64'h0000_0000_0000_0001; // +subnormal
      3:  return 64'h800F_FFFF_FFFF_FFFF; // -subnormal
      4:  return 64'h3FF0_0000_0000_0000; // 1.0
      5:  return 64'h4000_0000_0000_0000; // 2.0
      6:  return 64'hBFF0_0000_0000_0000; // -1.0
      7:  return 64'h7FEF_FFFF_FFFF_FFFF; // max finite
      8:  return 64'h7FF0_0000_0000_0000; // +inf
      9:  return 64'hFFF0_0000_0000_0000; // -inf
      10: return 64'h7FF8_0000_0000_0000; // qNaN
      default: return 64'h7FF0_0000_0000_0001; // sNaN
    endcase
  endfunction

  // Bench reference: field-based comparison, written independently of the RTL.
  function automatic logic [1:0] model(input logic [63:0] a, input logic [63:0] b,
                                       input logic [1:0] p);
    bit na, nb, sa, sb, za, zb;
    int rel, m;
    na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    sa = na && !a[51];
    sb = nb && !b[51];
    za = (a[62:52] == 0);
    zb = (b[62:52] == 0);
    if (na || nb) return {(p == 2'b01), (sa || sb || p[1])};
    if (za && zb)         rel = 0;
    else if (za)          rel = b[63] ? 1 : -1;
    else if (zb)          rel = a[63] ? -1 : 1;
    else if (a[63] != b[63]) rel = a[63] ? -1 : 1;
    else begin
      m   = (a[62:0] == b[62:0]) ? 0 : ((a[62:0] < b[62:0]) ? -1 : 1);
      rel = a[63] ? -m : m;
    end
    case (p)
      2'b00:   return {(rel == 0), 1'b0};
      2'b01:   return {(rel != 0), 1'b0};
      2'b10:   return {(rel < 0), 1'b0};
      default: return {(rel <= 0), 1'b0};
    endcase
  endfunction

  function automatic int cat(input logic [63:0] x);
    if (x[62:52] == 11'h7FF) return (x[51:0] != 0) ? 3 : 2;
    if (x[62:52] == 0) return 1;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [1:0] p,
                      input logic v, input logic [6:0] l);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_pred = p; in_vec = v; in_len = l;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_vec = 1'b1; in_pred = 2'b11; in_len = 7'd9;
      @(posedge clk);
    end
  endtask

  task automatic scalar_op(input logic [63:0] a, input logic [63:0] b,
                           input logic [1:0] p, input string extra);
    logic [1:0] r;
    string tag;
    int ca, cb;
    r  = model(a, b, p);
    ca = cat(a); cb = cat(b);
    tag = {"R1 R2", extra};
    if (ca == 1 || cb == 1) tag = {tag, " R3"};
    if (ca == 2 || cb == 2) tag = {tag, " R4"};
    if (ca == 3 || cb == 3) tag = {tag, " R5 R6"};
    send(a, b, p, 1'b0, 7'd5);
    q_data.push_back({64{r[1]}});
    q_inv.push_back(r[0]);
    q_tag.push_back(tag);
  endtask

  task automatic vec_op(input logic [1:0] p, input logic [6:0] len,
                        input bit gaps, input string extra);
    int eff;
    logic [63:0] mask, a, b;
    logic inv;
    logic [1:0] r;
    eff  = (len == 0) ? 1 : ((len > 64) ? 64 : int'(len));
    mask = '0; inv = 1'b0;
    for (int i = 0; i < eff; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a  = val(int'(lf[3:0]) % 12);
      b  = val(int'(lf[9:6]) % 12);
      r  = model(a, b, p);
      mask[i] = r[1];
      inv = inv | r[0];
      // later pairs carry scalar mode, another predicate and another length (R7)
      if (i == 0) send(a, b, p, 1'b1, len);
      else        send(a, b, ~p, 1'b0, 7'd2);
      if (gaps && (i % 5 == 2) && (i != eff - 1)) idle(1);
    end
    q_data.push_back(mask);
    q_inv.push_back(inv);
    q_tag.push_back({"R7 R8 R6", extra});
  endtask

  // Monitor: compare each result against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R1 R7 unexpected result", out_data, '0);
      end else begin
        logic [63:0] ed;
        logic ei;
        string t;
        ed = q_data.pop_front();
        ei = q_inv.pop_front();
        t  = q_tag.pop_front();
        check(out_data == ed, {t, " data"}, out_data, ed);
        check(out_invalid == ei, {t, " invalid flag"}, 64'(out_invalid), 64'(ei));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid in reset", 64'(out_valid), 64'd0);
    check(out_data == '0, "R9 out_data in reset", out_data, 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R9 in_ready after reset", 64'(in_ready), 64'd1);

    // Scalar sweep: every pair of special and ordinary values, all predicates.
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int p = 0; p < 4; p++)
          scalar_op(val(i), val(j), 2'(p), "");
    idle(2);

    // Vector runs: several lengths and predicates, with and without gaps.
    vec_op(2'b00, 7'd1, 1'b0, "");
    vec_op(2'b10, 7'd5, 1'b1, "");
    vec_op(2'b11, 7'd64, 1'b1, "");
    vec_op(2'b01, 7'd70, 1'b0, "");
    vec_op(2'b10, 7'd0, 1'b0, "");
    vec_op(2'b11, 7'd17, 1'b0, "");
    idle(2);

    // Back-to-back boundaries (R10).
    vec_op(2'b10, 7'd4, 1'b0, " R10");
    scalar_op(val(10), val(4), 2'b11, " R10");
    vec_op(2'b00, 7'd3, 1'b0, " R10");
    vec_op(2'b01, 7'd6, 1'b0, " R10");
    scalar_op(val(1), val(2), 2'b00, " R10");
    idle(4);

    check(q_data.size() == 0, "R1 R7 results outstanding", 64'(q_data.size()), 64'd0);
    check(in_ready == 1'b1, "R9 in_ready held", 64'(in_ready), 64'd1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule